// File: doc/BRIEF.md
# Fracturable Look-Up Table Slice

This block is one logic slice made of four truth-table function generators, called A, B, C and D. Each generator holds 64 truth bits and has six address inputs. In full mode a generator computes any six-input Boolean function and gives the result on its `o6` bit. In split mode the top address input is held at 1. The lower five inputs then address two 32-entry halves at once: the lower half drives `o5` and the upper half drives `o6`. This gives two five-input functions on shared inputs. It can equally hold two unrelated functions of at most three and two inputs each. The lookup path has no registers and has the same depth whatever function is loaded.

Two first-level wide multiplexers each join the `o6` results of a pair of generators (A with B, C with D) into one seven-input result. A second-level multiplexer picks between those two results, so the whole slice can realise any eight-input function. Each multiplexer select is a dedicated input.

The truth bits enter through a serial configuration stream of 256 bits that uses a valid/ready handshake. The slice never applies back-pressure: `cfg_ready` is always high, and one bit is taken on every clock edge at which `cfg_valid` is high. The stream carries table D first and table A last, and each table is sent from entry 63 down to entry 0. Lookup outputs are not meaningful while a load is in progress.

Top module: `frac_lut_slice`

## Requirements
- R1: An active-low asynchronous reset clears all 256 truth bits, so every lookup and multiplexer output reads 0 after reset, whatever the address and select inputs are.
- R2: On each rising clock edge at which `cfg_valid` is high, one `cfg_bit` is accepted and `cfg_ready` is always 1. After 256 accepted bits, the first bit accepted is table D entry 63 and the last bit accepted is table A entry 0. The stream runs D, C, B, A, and within each table from the highest entry to the lowest.
- R3: For each table, `o6` equals the truth bit at index `{in[5],in[4],...,in[0]}`, where port bit 0 is the least significant address bit.
- R4: For each table, `o5` equals the truth bit at index `{0,in[4:0]}` and does not depend on `in[5]`.
- R5: With `in[5]` held at 1, a table gives two five-input functions on the same five inputs: `o6` from entries 32 to 63 and `o5` from entries 0 to 31.
- R6: `f7_ab` equals table A's `o6` when `sel_ab` is 0 and table B's `o6` when it is 1. `f7_cd` equals table C's `o6` when `sel_cd` is 0 and table D's `o6` when it is 1.
- R7: `f8` equals `f7_ab` when `sel_f8` is 0 and `f7_cd` when it is 1. When all four tables get the same six inputs and `sel_ab` equals `sel_cd`, `f8` is the eight-input function whose index is `{sel_f8, sel_ab, in[5:0]}`, with tables ordered A, B, C, D as index bits 7..6 go from 00 to 11.
- R8: Every lookup and multiplexer output follows a change of its address or select inputs within the same clock cycle, with no register on the path.
- R9: While `cfg_valid` is low, the truth bits keep their values and `cfg_bit` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration stream |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Configuration bit is valid this cycle |
| cfg_bit | input | 1 | Serial configuration data |
| cfg_ready | output | 1 | Always 1; the stream is never stalled |
| in_a | input | 6 | Address inputs of table A |
| in_b | input | 6 | Address inputs of table B |
| in_c | input | 6 | Address inputs of table C |
| in_d | input | 6 | Address inputs of table D |
| sel_ab | input | 1 | Select of the A/B seven-input multiplexer |
| sel_cd | input | 1 | Select of the C/D seven-input multiplexer |
| sel_f8 | input | 1 | Select of the eight-input multiplexer |
| o6 | output | 4 | Six-input results, bit 0 = A to bit 3 = D |
| o5 | output | 4 | Lower-half results, bit 0 = A to bit 3 = D |
| f7_ab | output | 1 | Seven-input result from tables A and B |
| f7_cd | output | 1 | Seven-input result from tables C and D |
| f8 | output | 1 | Eight-input result from all four tables |

## Verification
After random truth tables are loaded, the bench sweeps all 256 combinations of shared inputs and pair selects. This sweep separates a wrong table order or a select polarity swapped anywhere in the multiplexer tree. Random independent addresses and selects per table expose crossed address wiring between tables. A phase with the top address input held high separates the two halves and shows any wrongly dependent `o5`. Two sparse streams, each carrying a single 1 at its first or last position, pin down the stream order and the direction within each table. Idle gaps with random `cfg_bit` placed inside and after loads show that data outside valid cycles is ignored.

// File: rtl/lutslice_pkg.sv
package lutslice_pkg;
  // Slice-level geometry shared by the slice and its parts.
  localparam int DEF_LUT_K  = 6;
  localparam int NUM_LUT    = 4;
  localparam int PAIR_COUNT = NUM_LUT / 2;

  // Table positions inside the slice; the wide multiplexer tree relies on
  // this order (A,B form the low pair, C,D the high pair).
  typedef enum logic [1:0] {
    TBL_A = 2'd0,
    TBL_B = 2'd1,
    TBL_C = 2'd2,
    TBL_D = 2'd3
  } tbl_id_e;
endpackage

// File: rtl/lut_cfg_chain.sv
module lut_cfg_chain #(
  parameter int DEPTH = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             shift_bit,
  output logic [DEPTH-1:0] image
);
  // Serial truth image: the newest bit enters at index 0, so the first
  // bit of a full load ends at the top index.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      image <= '0;
    end else if (shift_en) begin
      image <= {image[DEPTH-2:0], shift_bit};
    end
  end
endmodule

// File: rtl/frac_lut6.sv
module frac_lut6 #(
  parameter int K = 6
) (
  input  logic [(1<<K)-1:0] truth,
  input  logic [K-1:0]      addr,
  output logic              o6,
  output logic              o5
);
  logic [K-1:0] low_addr;

  // The split output ignores the top address bit and reads the low half.
  assign low_addr = {1'b0, addr[K-2:0]};
  assign o6       = truth[addr];
  assign o5       = truth[low_addr];
endmodule

// File: rtl/wide_mux_tree.sv
module wide_mux_tree
  import lutslice_pkg::*;
(
  input  logic [NUM_LUT-1:0]    leaf,
  input  logic [PAIR_COUNT-1:0] pair_sel,
  input  logic                  top_sel,
  output logic [PAIR_COUNT-1:0] pair_out,
  output logic                  top_out
);
  for (genvar p = 0; p < PAIR_COUNT; p++) begin : g_pair
    assign pair_out[p] = pair_sel[p] ? leaf[2*p+1] : leaf[2*p];
  end

  assign top_out = top_sel ? pair_out[1] : pair_out[0];
endmodule

// File: rtl/frac_lut_slice.sv
module frac_lut_slice
  import lutslice_pkg::*;
#(
  parameter int LUT_K = DEF_LUT_K
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_valid,
  input  logic               cfg_bit,
  output logic               cfg_ready,
  input  logic [LUT_K-1:0]   in_a,
  input  logic [LUT_K-1:0]   in_b,
  input  logic [LUT_K-1:0]   in_c,
  input  logic [LUT_K-1:0]   in_d,
  input  logic               sel_ab,
  input  logic               sel_cd,
  input  logic               sel_f8,
  output logic [NUM_LUT-1:0] o6,
  output logic [NUM_LUT-1:0] o5,
  output logic               f7_ab,
  output logic               f7_cd,
  output logic               f8
);
  localparam int TT_BITS  = 1 << LUT_K;
  localparam int CFG_BITS = NUM_LUT * TT_BITS;

  logic [CFG_BITS-1:0]   image;
  logic [LUT_K-1:0]      lut_addr [NUM_LUT];
  logic [PAIR_COUNT-1:0] pair_out;

  // The stream is never stalled; a bit moves on every valid cycle.
  assign cfg_ready = 1'b1;

  lut_cfg_chain #(.DEPTH(CFG_BITS)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (cfg_valid),
    .shift_bit (cfg_bit),
    .image     (image)
  );

  assign lut_addr[TBL_A] = in_a;
  assign lut_addr[TBL_B] = in_b;
  assign lut_addr[TBL_C] = in_c;
  assign lut_addr[TBL_D] = in_d;

  // Table t owns image slice t; table D sits at the top of the image and
  // is therefore the first table of a load.
  for (genvar t = 0; t < NUM_LUT; t++) begin : g_lut
    frac_lut6 #(.K(LUT_K)) u_lut (
      .truth (image[t*TT_BITS +: TT_BITS]),
      .addr  (lut_addr[t]),
      .o6    (o6[t]),
      .o5    (o5[t])
    );
  end

  wide_mux_tree u_mux (
    .leaf     (o6),
    .pair_sel ({sel_cd, sel_ab}),
    .top_sel  (sel_f8),
    .pair_out (pair_out),
    .top_out  (f8)
  );

  assign f7_ab = pair_out[0];
  assign f7_cd = pair_out[1];
endmodule

// File: rtl/frac_lut_slice_chk.sv
module frac_lut_slice_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_valid,
  input logic [5:0] in_a,
  input logic [5:0] in_b,
  input logic [5:0] in_c,
  input logic [5:0] in_d,
  input logic       sel_ab,
  input logic       sel_cd,
  input logic       sel_f8,
  input logic [3:0] o6,
  input logic [3:0] o5,
  input logic       f7_ab,
  input logic       f7_cd,
  input logic       f8
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  // R4: with the top address bit low both outputs read the same entry.
  p_split_agree_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_a[5] |-> o5[0] == o6[0]) and (!in_b[5] |-> o5[1] == o6[1]) and
    (!in_c[5] |-> o5[2] == o6[2]) and (!in_d[5] |-> o5[3] == o6[3]));

  // R6: pair multiplexers pass the chosen table.
  p_pair_ab_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ab |-> f7_ab == o6[1]);
  p_pair_ab0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_ab |-> f7_ab == o6[0]);
  p_pair_cd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sel_cd |-> f7_cd == o6[3]);
  p_pair_cd0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_cd |-> f7_cd == o6[2]);

  // R7: second-level multiplexer.
  p_top_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_f8 |-> f8 == f7_cd);
  p_top_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_f8 |-> f8 == f7_ab);

  // R9: with no shift since the last edge and steady addresses, outputs hold.
  p_hold_a_r9: assert property (@(posedge clk) disable iff (!rst_n)
    seen && !$past(cfg_valid) && $stable(in_a) |-> $stable(o6[0]) && $stable(o5[0]));
  p_hold_d_r9: assert property (@(posedge clk) disable iff (!rst_n)
    seen && !$past(cfg_valid) && $stable(in_d) |-> $stable(o6[3]) && $stable(o5[3]));
endmodule

bind frac_lut_slice frac_lut_slice_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid),
  .in_a(in_a), .in_b(in_b), .in_c(in_c), .in_d(in_d),
  .sel_ab(sel_ab), .sel_cd(sel_cd), .sel_f8(sel_f8),
  .o6(o6), .o5(o5), .f7_ab(f7_ab), .f7_cd(f7_cd), .f8(f8)
);

// File: tb/tb_frac_lut_slice.sv
`timescale 1ns/1ps
module tb_frac_lut_slice;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_valid = 1'b0;
  logic       cfg_bit = 1'b0;
  logic       cfg_ready;
  logic [5:0] lin [4];
  logic       sel_ab = 1'b0, sel_cd = 1'b0, sel_f8 = 1'b0;
  logic [3:0] o6, o5;
  logic       f7_ab, f7_cd, f8;

  int    errors = 0;
  int    checks = 0;
  bit    chk_on = 1'b0;
  string cur_req = "R1";
  logic [63:0] tt_m [4];

  always #2.5 clk = ~clk;

  frac_lut_slice dut (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_bit(cfg_bit),
    .cfg_ready(cfg_ready), .in_a(lin[0]), .in_b(lin[1]), .in_c(lin[2]),
    .in_d(lin[3]), .sel_ab(sel_ab), .sel_cd(sel_cd), .sel_f8(sel_f8),
    .o6(o6), .o5(o5), .f7_ab(f7_ab), .f7_cd(f7_cd), .f8(f8)
  );

  task automatic check1(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  // Reference model compared on every falling edge (R8: inputs change just
  // after the rising edge, results must be there in the same cycle).
  always @(negedge clk) begin
    if (chk_on) begin
      logic [3:0] e6, e5;
      logic ea, ec, e8;
      logic [10:0] exp_v, act_v;
      for (int t = 0; t < 4; t++) begin
        e6[t] = tt_m[t][lin[t]];
        e5[t] = tt_m[t][lin[t] % 32];
      end
      ea = sel_ab ? e6[1] : e6[0];
      ec = sel_cd ? e6[3] : e6[2];
      e8 = sel_f8 ? ec : ea;
      exp_v = {e6, e5, ea, ec, e8};
      act_v = {o6, o5, f7_ab, f7_cd, f8};
      checks++;
      if (act_v !== exp_v || cfg_ready !== 1'b1) begin
        errors++;
        $display("FAIL %s R8: got %b ready=%b expected %b ready=1",
                 cur_req, act_v, cfg_ready, exp_v);
      end
    end
  end

  // Load a 256-bit stream, with idle gaps carrying random data (R9).
  task automatic load(input bit s [256]);
    chk_on = 1'b0;
    for (int k = 0; k < 256; k++) begin
      if (k % 37 == 11) begin
        @(negedge clk);
        cfg_valid = 1'b0;
        cfg_bit   = 1'($urandom);
      end
      @(negedge clk);
      cfg_valid = 1'b1;
      cfg_bit   = s[k];
    end
    @(negedge clk);
    cfg_valid = 1'b0;
    cfg_bit   = 1'($urandom);
    for (int k = 0; k < 256; k++) tt_m[3 - k/64][63 - k%64] = s[k];
    chk_on = 1'b1;
  endtask

  task automatic drive(logic [5:0] a, logic [5:0] b, logic [5:0] c, logic [5:0] d,
                       logic sab, logic scd, logic s8);
    @(posedge clk);
    #1;
    lin[0] = a; lin[1] = b; lin[2] = c; lin[3] = d;
    sel_ab = sab; sel_cd = scd; sel_f8 = s8;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit s [256];
    for (int t = 0; t < 4; t++) begin lin[t] = 6'd0; tt_m[t] = '0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: cleared tables under several patterns.
    cur_req = "R1";
    chk_on = 1'b1;
    for (int n = 0; n < 8; n++)
      drive(6'($urandom), 6'($urandom), 6'($urandom), 6'($urandom),
            1'($urandom), 1'($urandom), 1'($urandom));
    @(negedge clk);
    check1("R1 o6", |o6, 1'b0);
    check1("R1 f8", f8, 1'b0);

    // R2: only the first stream bit set -> table D entry 63.
    for (int k = 0; k < 256; k++) s[k] = 1'b0;
    s[0] = 1'b1;
    cur_req = "R2";
    load(s);
    drive(6'd0, 6'd0, 6'd0, 6'h3f, 1'b0, 1'b1, 1'b1);
    @(negedge clk);
    check1("R2 D entry 63", o6[3], 1'b1);
    check1("R4 D low half", o5[3], 1'b0);
    check1("R7 f8 from D", f8, 1'b1);
    check1("R2 A entry 0", o6[0], 1'b0);

    // R2: only the last stream bit set -> table A entry 0.
    for (int k = 0; k < 256; k++) s[k] = 1'b0;
    s[255] = 1'b1;
    load(s);
    drive(6'd0, 6'd0, 6'd0, 6'h3f, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    check1("R2 A entry 0", o6[0], 1'b1);
    check1("R2 D entry 63", o6[3], 1'b0);
    drive(6'h20, 6'd0, 6'd0, 6'd0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    check1("R4 A ignores in[5]", o5[0], 1'b1);
    check1("R3 A entry 32", o6[0], 1'b0);

    // Random tables.
    for (int k = 0; k < 256; k++) s[k] = 1'($urandom);
    load(s);

    // R7: full eight-input sweep with shared inputs.
    cur_req = "R7";
    for (int x = 0; x < 256; x++) begin
      drive(6'(x), 6'(x), 6'(x), 6'(x), 1'(x >> 6), 1'(x >> 6), 1'(x >> 7));
      @(negedge clk);
      check1("R7 eight-input", f8, tt_m[x >> 6][x % 64]);
    end

    // R3 R4 R6: independent addresses and selects.
    cur_req = "R3 R4 R6";
    for (int n = 0; n < 300; n++)
      drive(6'($urandom), 6'($urandom), 6'($urandom), 6'($urandom),
            1'($urandom), 1'($urandom), 1'($urandom));

    // R5: split mode, top input held high.
    cur_req = "R5";
    for (int x = 0; x < 32; x++) begin
      drive(6'(32 + x), 6'(32 + x), 6'(32 + x), 6'(32 + x), 1'b0, 1'b1, 1'b0);
      @(negedge clk);
      check1("R5 upper half", o6[2], tt_m[2][32 + x]);
      check1("R5 lower half", o5[2], tt_m[2][x]);
    end

    // R9: idle with toggling data, contents must stay.
    cur_req = "R9";
    for (int n = 0; n < 40; n++) begin
      @(negedge clk);
      cfg_bit = ~cfg_bit;
    end
    for (int n = 0; n < 64; n++)
      drive(6'(n), 6'(63 - n), 6'(n), 6'(63 - n), 1'(n), 1'(n >> 1), 1'(n >> 2));

    @(negedge clk);
    chk_on = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule